// File: doc/BRIEF.md
# D-Channel HDLC Frame Receiver

This block recovers packets from the serial bit stream of a low-speed signaling channel. Each incoming bit arrives with a one-cycle valid strobe. The receiver finds frame boundaries by their flag pattern and drops stuffed zeros. It packs the payload into bytes, least significant bit first, and checks the 16-bit frame check sequence at the closing flag. Recovered bytes leave on a byte port with a valid strobe and an end-of-packet marker. Packet start, packet end, abort and check status are reported on dedicated outputs.

The last complete byte of a frame is held back by one byte. This lets the end-of-packet marker sit on the true final byte. When a frame is aborted, by a run of ones on the line or by a command input, that held byte is still delivered, and the abort is posted in the same beat. The status left by the previous good or bad frame stays untouched after an abort.

Between frames the line may idle with continuous ones or with repeated flags. A flag that closes one packet can open the next one directly.

Top module: `dchan_frame_rx`

## Requirements
- R1: A flag is the bit sequence 0,1,1,1,1,1,1,0. The bits between an opening and a closing flag are packed into bytes with the first received bit in bit 0 of `data_o`. Each byte appears with `data_valid_o` high for one cycle.
- R2: Inside a frame, a 0 that follows five consecutive 1s is removed and does not enter any byte.
- R3: At a closing flag, `fcs_ok_o` is set when two conditions hold. First, a reflected CRC-16 (polynomial 0x8408 in reflected form, preset 0xFFFF), run over every byte including the two check bytes, leaves 0xF0B8. Second, the frame ended on a byte boundary. If either condition fails, `fcs_ok_o` is cleared. The check bytes are the inverted CRC, low byte first.
- R4: At a closing flag, `short_frame_o` is set when fewer than 4 bytes were received between the flags, and cleared otherwise.
- R5: `pkt_start_o` pulses when the first byte of a frame completes. The final byte of a frame is output with `data_eop_o` high, in the same cycle as a `pkt_end_o` pulse. No other byte carries `data_eop_o`.
- R6: A single flag between two frames closes the first and opens the second. Both frames are reported.
- R7: Idle fill of continuous 1s, or of back-to-back flags, produces no byte, no start and no end.
- R8: Seven consecutive 1s inside a frame abort it. The held last byte is output with `data_eop_o`, together with `pkt_abort_o` and `pkt_end_o`, in one cycle. Later bits are ignored until the next flag.
- R9: An abort leaves `fcs_ok_o` and `short_frame_o` unchanged and clears `pkt_active_o`. `pkt_active_o` is high from the first byte of a frame until its end.
- R10: A high `rx_abort_cmd_i` in any cycle aborts a frame in progress in the same way as R8.
- R11: `abort_irq_o` is high in the abort cycle only when `abort_irq_en_i` is 1.
- R12: After reset, all outputs are 0 and the receiver hunts for a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_bit_i | input | 1 | Serial line bit |
| rx_bit_valid_i | input | 1 | One-cycle strobe qualifying rx_bit_i |
| rx_abort_cmd_i | input | 1 | Command to abort the frame being received |
| abort_irq_en_i | input | 1 | Abort interrupt enable (0 masks) |
| data_o | output | 8 | Recovered byte |
| data_valid_o | output | 1 | data_o valid for one cycle |
| data_eop_o | output | 1 | Byte is the last of its packet |
| pkt_start_o | output | 1 | First byte of a packet completed |
| pkt_end_o | output | 1 | Packet ended (closing flag or abort) |
| pkt_abort_o | output | 1 | Packet ended by abort |
| fcs_ok_o | output | 1 | Check result of the last closed packet |
| short_frame_o | output | 1 | Last closed packet had fewer than 4 bytes |
| pkt_active_o | output | 1 | Packet reception in progress |
| abort_irq_o | output | 1 | Maskable abort interrupt |

## Verification
The checker enforces the framing relations on every cycle:
- an abort always coincides with an end-of-packet byte;
- every end-of-packet byte coincides with a packet end;
- status holds across an abort;
- the activity flag is consistent with start and end;
- no byte appears without a line bit or command in the cycle before;
- the interrupt respects its enable.

Only the directed scenarios can show the rest:
- bytes are recovered with the correct value and order after zero deletion;
- the check sequence is judged right and wrong correctly;
- short frames are detected;
- idle fill of both kinds produces no output;
- a shared flag yields two packets;
- the line abort and the commanded abort each deliver the proper held byte.

// File: rtl/dchan_rx_pkg.sv
package dchan_rx_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned FCS_W = 16;
  localparam logic [FCS_W-1:0] FCS_POLY_R = 16'h8408;
  localparam logic [FCS_W-1:0] FCS_PRESET = 16'hFFFF;
  localparam logic [FCS_W-1:0] FCS_GOOD = 16'hF0B8;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_OPEN = 2'd1,
    ST_DATA = 2'd2
  } rx_state_e;

  function automatic logic [FCS_W-1:0] fcs_step(input logic [FCS_W-1:0] c,
                                                input logic [BYTE_W-1:0] d);
    logic [FCS_W-1:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < int'(BYTE_W); i++) begin
      fb = r[0] ^ d[i];
      r = r >> 1;
      if (fb) r = r ^ FCS_POLY_R;
    end
    return r;
  endfunction
endpackage

// File: rtl/dchan_rx_line.sv
// Ones-run tracking: flag, abort and stuffed-zero detection.
module dchan_rx_line #(
  parameter int unsigned FLAG_RUN = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic valid_i,
  output logic push_o,
  output logic bit_o,
  output logic flag_o,
  output logic abort_o
);
  localparam int unsigned RUN_MAX = FLAG_RUN + 1;
  localparam int unsigned RUN_W = $clog2(RUN_MAX + 1);

  logic [RUN_W-1:0] run_q;
  logic stuff_w;

  assign flag_o  = valid_i && !bit_i && (run_q == RUN_W'(FLAG_RUN));
  assign stuff_w = valid_i && !bit_i && (run_q == RUN_W'(FLAG_RUN - 1));
  assign abort_o = valid_i && bit_i && (run_q == RUN_W'(FLAG_RUN));
  assign push_o  = valid_i && !flag_o && !stuff_w;
  assign bit_o   = bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
    end else if (valid_i) begin
      if (!bit_i) run_q <= '0;
      else if (run_q != RUN_W'(RUN_MAX)) run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/dchan_rx_deser.sv
// LSB-first byte assembly.
module dchan_rx_deser #(
  parameter int unsigned W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 push_i,
  input  logic                 bit_i,
  output logic                 done_o,
  output logic [W-1:0]         byte_o,
  output logic [$clog2(W)-1:0] cnt_o
);
  localparam int unsigned CW = $clog2(W);

  logic [W-1:0]  sh_q;
  logic [CW-1:0] cnt_q;

  assign byte_o = {bit_i, sh_q[W-1:1]};
  assign done_o = push_i && (cnt_q == CW'(W - 1));
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (push_i) begin
      sh_q  <= byte_o;
      cnt_q <= done_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/dchan_rx_fcs.sv
module dchan_rx_fcs
  import dchan_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              upd_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              ok_o
);
  logic [FCS_W-1:0] crc_q;

  assign ok_o = (crc_q == FCS_GOOD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= FCS_PRESET;
    else if (init_i) crc_q <= FCS_PRESET;
    else if (upd_i)  crc_q <= fcs_step(crc_q, byte_i);
  end
endmodule

// File: rtl/dchan_frame_rx.sv
module dchan_frame_rx
  import dchan_rx_pkg::*;
#(
  parameter int unsigned FLAG_RUN  = 6,
  parameter int unsigned MIN_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_bit_i,
  input  logic              rx_bit_valid_i,
  input  logic              rx_abort_cmd_i,
  input  logic              abort_irq_en_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              data_valid_o,
  output logic              data_eop_o,
  output logic              pkt_start_o,
  output logic              pkt_end_o,
  output logic              pkt_abort_o,
  output logic              fcs_ok_o,
  output logic              short_frame_o,
  output logic              pkt_active_o,
  output logic              abort_irq_o
);
  localparam int unsigned BC_W = $clog2(MIN_BYTES + 1);
  localparam int unsigned BIT_CW = $clog2(BYTE_W);
  // bit count left in the deserializer when a flag lands on a byte boundary
  localparam int unsigned ALIGN_CNT = (FLAG_RUN + 1) % BYTE_W;

  logic push_w, lbit_w, flag_w, abort_w;
  logic done_w, fcs_w;
  logic [BYTE_W-1:0] byte_w;
  logic [BIT_CW-1:0] bitcnt_w;

  rx_state_e         state_q;
  logic [BYTE_W-1:0] hold_q, data_q;
  logic [BC_W-1:0]   nbytes_q;
  logic valid_q, eop_q, start_q, end_q, abort_q, ok_q, short_q, active_q;
  logic kill_w;

  dchan_rx_line #(.FLAG_RUN(FLAG_RUN)) u_line (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bit_i   (rx_bit_i),
    .valid_i (rx_bit_valid_i),
    .push_o  (push_w),
    .bit_o   (lbit_w),
    .flag_o  (flag_w),
    .abort_o (abort_w)
  );

  dchan_rx_deser #(.W(BYTE_W)) u_deser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (flag_w),
    .push_i (push_w),
    .bit_i  (lbit_w),
    .done_o (done_w),
    .byte_o (byte_w),
    .cnt_o  (bitcnt_w)
  );

  dchan_rx_fcs u_fcs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (flag_w),
    .upd_i  (done_w),
    .byte_i (byte_w),
    .ok_o   (fcs_w)
  );

  assign kill_w = rx_abort_cmd_i || abort_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_HUNT;
      hold_q   <= '0;
      data_q   <= '0;
      nbytes_q <= '0;
      valid_q  <= 1'b0;
      eop_q    <= 1'b0;
      start_q  <= 1'b0;
      end_q    <= 1'b0;
      abort_q  <= 1'b0;
      ok_q     <= 1'b0;
      short_q  <= 1'b0;
      active_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      eop_q   <= 1'b0;
      start_q <= 1'b0;
      end_q   <= 1'b0;
      abort_q <= 1'b0;
      unique case (state_q)
        ST_HUNT: begin
          if (flag_w && !rx_abort_cmd_i) state_q <= ST_OPEN;
        end
        ST_OPEN: begin
          if (kill_w) begin
            state_q <= ST_HUNT;
          end else if (done_w) begin
            state_q  <= ST_DATA;
            hold_q   <= byte_w;
            nbytes_q <= BC_W'(1);
            start_q  <= 1'b1;
            active_q <= 1'b1;
          end
        end
        ST_DATA: begin
          if (kill_w) begin
            data_q   <= hold_q;
            valid_q  <= 1'b1;
            eop_q    <= 1'b1;
            end_q    <= 1'b1;
            abort_q  <= 1'b1;
            active_q <= 1'b0;
            state_q  <= ST_HUNT;
          end else if (flag_w) begin
            data_q   <= hold_q;
            valid_q  <= 1'b1;
            eop_q    <= 1'b1;
            end_q    <= 1'b1;
            active_q <= 1'b0;
            ok_q     <= fcs_w && (bitcnt_w == BIT_CW'(ALIGN_CNT));
            short_q  <= (nbytes_q < BC_W'(MIN_BYTES));
            state_q  <= ST_OPEN;
          end else if (done_w) begin
            data_q  <= hold_q;
            valid_q <= 1'b1;
            hold_q  <= byte_w;
            if (nbytes_q != BC_W'(MIN_BYTES)) nbytes_q <= nbytes_q + 1'b1;
          end
        end
        default: state_q <= ST_HUNT;
      endcase
    end
  end

  assign data_o        = data_q;
  assign data_valid_o  = valid_q;
  assign data_eop_o    = eop_q;
  assign pkt_start_o   = start_q;
  assign pkt_end_o     = end_q;
  assign pkt_abort_o   = abort_q;
  assign fcs_ok_o      = ok_q;
  assign short_frame_o = short_q;
  assign pkt_active_o  = active_q;
  assign abort_irq_o   = abort_q && abort_irq_en_i;
endmodule

// File: rtl/dchan_rx_chk.sv
module dchan_rx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rx_bit_valid_i,
  input logic       rx_abort_cmd_i,
  input logic       abort_irq_en_i,
  input logic       data_valid_o,
  input logic       data_eop_o,
  input logic       pkt_start_o,
  input logic       pkt_end_o,
  input logic       pkt_abort_o,
  input logic       fcs_ok_o,
  input logic       short_frame_o,
  input logic       pkt_active_o,
  input logic       abort_irq_o
);
  p_abort_on_eop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_abort_o |-> (data_valid_o && data_eop_o && pkt_end_o));

  p_eop_is_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_valid_o && data_eop_o) |-> pkt_end_o);

  p_eop_only_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_eop_o |-> data_valid_o);

  p_status_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_abort_o |-> ($stable(fcs_ok_o) && $stable(short_frame_o)));

  p_active_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_end_o |-> !pkt_active_o);

  p_start_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_start_o |-> (pkt_active_o && !data_valid_o && !pkt_end_o));

  p_byte_needs_cause_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> $past(rx_bit_valid_i || rx_abort_cmd_i));

  p_irq_mask_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_irq_o |-> (pkt_abort_o && abort_irq_en_i));

  p_pulses_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pkt_start_o, pkt_end_o}));
endmodule

bind dchan_frame_rx dchan_rx_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .rx_bit_valid_i (rx_bit_valid_i),
  .rx_abort_cmd_i (rx_abort_cmd_i),
  .abort_irq_en_i (abort_irq_en_i),
  .data_valid_o   (data_valid_o),
  .data_eop_o     (data_eop_o),
  .pkt_start_o    (pkt_start_o),
  .pkt_end_o      (pkt_end_o),
  .pkt_abort_o    (pkt_abort_o),
  .fcs_ok_o       (fcs_ok_o),
  .short_frame_o  (short_frame_o),
  .pkt_active_o   (pkt_active_o),
  .abort_irq_o    (abort_irq_o)
);

// File: tb/dchan_frame_rx_test.sv
module dchan_frame_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_bit = 1'b1, rx_valid = 1'b0, abort_cmd = 1'b0, irq_en = 1'b1;
  logic [7:0] data;
  logic data_valid, data_eop, pkt_start, pkt_end, pkt_abort;
  logic fcs_ok, short_frame, pkt_active, abort_irq;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dchan_frame_rx uut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .rx_bit_i       (rx_bit),
    .rx_bit_valid_i (rx_valid),
    .rx_abort_cmd_i (abort_cmd),
    .abort_irq_en_i (irq_en),
    .data_o         (data),
    .data_valid_o   (data_valid),
    .data_eop_o     (data_eop),
    .pkt_start_o    (pkt_start),
    .pkt_end_o      (pkt_end),
    .pkt_abort_o    (pkt_abort),
    .fcs_ok_o       (fcs_ok),
    .short_frame_o  (short_frame),
    .pkt_active_o   (pkt_active),
    .abort_irq_o    (abort_irq)
  );

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  // capture
  logic [7:0] cap [0:63];
  logic       cap_eop [0:63];
  int cap_n = 0, n_start = 0, n_end = 0, n_abort = 0, n_irq = 0, n_ok = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (data_valid && cap_n < 64) begin
        cap[cap_n] = data;
        cap_eop[cap_n] = data_eop;
        cap_n++;
      end
      if (pkt_start) n_start++;
      if (pkt_end) n_end++;
      if (pkt_end && fcs_ok && !pkt_abort) n_ok++;
      if (pkt_abort) n_abort++;
      if (abort_irq) n_irq++;
    end
  end

  task automatic clear_cap();
    cap_n = 0; n_start = 0; n_end = 0; n_abort = 0; n_irq = 0; n_ok = 0;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // line driver with bench-side zero stuffing
  int ones = 0;

  task automatic send_bit(input logic b);
    @(negedge clk);
    rx_bit = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_flag();
    send_bit(1'b0);
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    send_bit(1'b0);
    ones = 0;
  endtask

  task automatic send_ones(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
    ones = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      send_bit(b[i]);
      if (b[i]) begin
        ones++;
        if (ones == 5) begin
          send_bit(1'b0);
          ones = 0;
        end
      end else begin
        ones = 0;
      end
    end
  endtask

  function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 16'h8408;
      else r = r >> 1;
    end
    return r;
  endfunction

  logic [7:0] pl [0:15];

  // payload + inverted CRC (low byte first); corrupt flips FCS bits
  task automatic send_body(input int n, input logic [15:0] corrupt);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      c = crc_upd(c, pl[i]);
      send_byte(pl[i]);
    end
    c = ~c ^ corrupt;
    send_byte(c[7:0]);
    send_byte(c[15:8]);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    check(!data_valid && !data_eop && !pkt_start && !pkt_end && !pkt_abort &&
          !fcs_ok && !short_frame && !pkt_active && !abort_irq, "R12", "outputs after reset",
          {data_valid, data_eop, pkt_start, pkt_end, pkt_abort, fcs_ok, short_frame,
           pkt_active, abort_irq}, 0);
    check(data == 8'h00, "R12", "data after reset", data, 0);
  endtask

  task automatic t_good_frame();
    logic [7:0] exp_b [0:5];
    logic [15:0] c = 16'hFFFF;
    bit match = 1'b1, eop_ok = 1'b1;
    clear_cap();
    pl[0] = 8'hA5; pl[1] = 8'h7E; pl[2] = 8'hFF; pl[3] = 8'h3E;
    for (int i = 0; i < 4; i++) begin
      c = crc_upd(c, pl[i]);
      exp_b[i] = pl[i];
    end
    exp_b[4] = ~c[7:0];
    exp_b[5] = ~c[15:8];
    send_ones(10);
    send_flag();
    send_body(4, 16'h0000);
    send_flag();
    send_ones(10);
    settle();
    check(cap_n == 6, "R1", "byte count good frame", cap_n, 6);
    for (int i = 0; i < 6; i++) begin
      if (cap[i] != exp_b[i]) match = 1'b0;
      if (cap_eop[i] != (i == 5)) eop_ok = 1'b0;
    end
    check(match, "R2", "bytes after zero deletion (7E,FF,3E)", cap[1], exp_b[1]);
    check(eop_ok, "R5", "eop only on last byte", cap_eop[5], 1);
    check(n_start == 1 && n_end == 1, "R5", "start/end count", n_start * 16 + n_end, 8'h11);
    check(fcs_ok == 1'b1, "R3", "fcs_ok good frame", fcs_ok, 1);
    check(short_frame == 1'b0, "R4", "short on 6-byte frame", short_frame, 0);
    check(n_abort == 0, "R8", "no abort on good frame", n_abort, 0);
  endtask

  task automatic t_bad_fcs();
    clear_cap();
    pl[0] = 8'h12; pl[1] = 8'h34; pl[2] = 8'h56;
    send_flag();
    send_body(3, 16'h0100);
    send_flag();
    send_ones(10);
    settle();
    check(n_end == 1, "R3", "bad frame ends", n_end, 1);
    check(fcs_ok == 1'b0, "R3", "fcs_ok bad frame", fcs_ok, 0);
    check(cap_n == 5, "R1", "byte count bad frame", cap_n, 5);
  endtask

  task automatic t_short();
    clear_cap();
    send_flag();
    send_byte(8'h01); send_byte(8'h02); send_byte(8'h03);
    send_flag();
    send_ones(10);
    settle();
    check(n_end == 1, "R4", "short frame ends", n_end, 1);
    check(short_frame == 1'b1, "R4", "short flag 3 bytes", short_frame, 1);
    check(cap_n == 3 && cap[0] == 8'h01 && cap[2] == 8'h03, "R1", "short frame bytes",
          cap[2], 8'h03);
  endtask

  task automatic t_idle();
    clear_cap();
    send_ones(20);
    send_flag(); send_flag(); send_flag(); send_flag();
    send_ones(20);
    settle();
    check(cap_n == 0 && n_start == 0 && n_end == 0, "R7", "idle fill output",
          cap_n + n_start + n_end, 0);
    check(pkt_active == 1'b0, "R7", "inactive during idle", pkt_active, 0);
  endtask

  task automatic t_shared_flag();
    clear_cap();
    pl[0] = 8'hC3; pl[1] = 8'h3C;
    send_flag();
    send_body(2, 16'h0000);
    send_flag();
    pl[0] = 8'h11; pl[1] = 8'h22; pl[2] = 8'h33;
    send_body(3, 16'h0000);
    send_flag();
    send_ones(10);
    settle();
    check(n_end == 2 && n_start == 2, "R6", "two packets via shared flag",
          n_start * 16 + n_end, 8'h22);
    check(n_ok == 2, "R6", "both frames fcs ok", n_ok, 2);
    check(cap_n == 9 && cap[4] == 8'h11 && cap_eop[3], "R6", "second frame starts after shared flag",
          cap[4], 8'h11);
  endtask

  task automatic t_line_abort(input logic en);
    logic prev_ok, prev_short;
    clear_cap();
    irq_en = en;
    prev_ok = fcs_ok;
    prev_short = short_frame;
    send_flag();
    send_byte(8'h21); send_byte(8'h42); send_byte(8'h63);
    send_ones(12);
    settle();
    check(cap_n == 3 && cap[2] == 8'h63 && cap_eop[2], "R8", "held byte out on abort",
          cap[2], 8'h63);
    check(n_abort == 1 && n_end == 1, "R8", "abort and end pulses", n_abort * 16 + n_end, 8'h11);
    check(fcs_ok == prev_ok && short_frame == prev_short, "R9", "status kept on abort",
          {fcs_ok, short_frame}, {prev_ok, prev_short});
    check(pkt_active == 1'b0, "R9", "active cleared", pkt_active, 0);
    check(n_irq == (en ? 1 : 0), "R11", "abort irq vs enable", n_irq, en ? 1 : 0);
    irq_en = 1'b1;
  endtask

  task automatic t_cmd_abort();
    clear_cap();
    send_flag();
    send_byte(8'h44); send_byte(8'h55);
    @(negedge clk);
    abort_cmd = 1'b1;
    @(negedge clk);
    abort_cmd = 1'b0;
    // remaining bits must be ignored until a flag; that flag only opens
    send_byte(8'h66); send_byte(8'h77);
    send_flag();
    send_ones(10);
    settle();
    check(cap_n == 2 && cap[1] == 8'h55 && cap_eop[1], "R10", "held byte on commanded abort",
          cap[1], 8'h55);
    check(n_abort == 1 && n_end == 1 && n_irq == 1, "R10", "single abort end",
          n_abort * 16 + n_end, 8'h11);
    check(n_start == 1, "R10", "no packet after abort", n_start, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_good_frame();
    t_bad_fcs();
    t_short();
    t_line_abort(1'b1);
    t_idle();
    t_shared_flag();
    t_line_abort(1'b0);
    t_cmd_abort();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule